// File: doc/BRIEF.md
# I3C Target-Initiated Request Sequencer

This block sits on the target side of an I3C bus and produces the symbol stream for requests the target starts on its own. There are three: joining the bus without an address (hot-join), asking for the controller role, and raising an in-band interrupt. The block works at the symbol level. It emits one START, address or data symbol per cycle. The pin drivers and the bus-available timers are outside it.

A request is a one-cycle pulse carrying a request code, the dynamic address, a 16-bit payload byte count, a 3-bit payload-limit code and a payload-capable flag. The request is checked first. A valid one then waits for a bus opening. If the bus is free, the target drives its own START. If the controller drives a START, the target joins it. The block sends the request header and takes the controller's acknowledge. An acknowledged interrupt may then carry a payload, which is pulled one byte per cycle from a byte source.

Each request ends in exactly one one-cycle outcome pulse: done, nack or error.

Top module: `i3c_tgt_req_seq`

## Requirements
- R1: After a synchronous reset, `busy`, `sym_valid`, `pay_take`, `done_o`, `nack_o` and `err_o` are all 0. Each request produces at most one of `done_o`, `nack_o` and `err_o`, as a one-cycle pulse.
- R2: Request code 8 (hot-join) sends the header byte {7'h02, 0}, which is 8'h04 on `sym_data`.
- R3: Request code 9 (controller-role request) sends the header byte {dyn_addr, 0}.
- R4: Request code 10 (in-band interrupt) sends the header byte {dyn_addr, 1}.
- R5: Symbol kinds on `sym_kind` are 0 = START, 1 = address header and 2 = data.
  - While waiting, a `ctrl_start` leads straight to the header, with no START. `ctrl_start` wins if `bus_avail` is also high.
  - Otherwise `bus_avail` leads to a START symbol, followed in the next cycle by the header.
- R6: Request codes other than 8, 9 and 10 are refused. The refusal is an `err_o` pulse one cycle after the request, and no symbol is emitted.
- R7: An interrupt with payload-capable set and a byte count greater than 2^`max_code` is refused with `err_o` before any symbol. A count equal to the limit is accepted.
- R8: A NACK at the acknowledge step gives a `nack_o` pulse, no payload, and a return to idle.
- R9: An acknowledged interrupt with payload-capable set and a non-zero count emits exactly `byte_cnt` data symbols. Each one carries `pay_byte` and is marked by `pay_take`. After them comes `done_o`.
- R10: Every payload byte has `sym_tbit` = 1, except the last, which has `sym_tbit` = 0.
- R11: In the following cases an ACK leads to `done_o` with no data symbols: hot-join, a controller-role request, an interrupt without payload-capable set, or an interrupt with a zero count.
- R12: A request pulse that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, accepted while idle |
| req_kind | input | 4 | Request code |
| dyn_addr | input | 7 | Target dynamic address |
| byte_cnt | input | 16 | Interrupt payload byte count |
| max_code | input | 3 | Payload limit code; limit = 2^code bytes |
| pay_capable | input | 1 | Target sends a payload after an acknowledged interrupt |
| bus_avail | input | 1 | Bus-available condition seen |
| ctrl_start | input | 1 | Controller drove a START |
| ack_valid | input | 1 | Acknowledge bit from the controller is valid |
| ack_nack | input | 1 | 1 = NACK, 0 = ACK |
| pay_byte | input | 8 | Next payload byte |
| pay_take | output | 1 | Current payload byte consumed |
| sym_valid | output | 1 | A symbol is emitted this cycle |
| sym_kind | output | 2 | 0 START, 1 header, 2 data |
| sym_data | output | 8 | Header byte or payload byte |
| sym_tbit | output | 1 | Data continuation bit |
| busy | output | 1 | Request in progress |
| done_o | output | 1 | Request completed |
| nack_o | output | 1 | Request was NACKed |
| err_o | output | 1 | Request refused |

## Verification
A corrupted state register or header latch shows within one symbol, in one of three ways:
- a wrong header byte;
- a START that should have been suppressed;
- a START with no header in the following cycle.

A payload counter that is off by one shows as an extra or missing data symbol, or as the zero continuation bit landing on the wrong byte. The scoreboard catches it by the end of that payload. A lost or doubled outcome pulse leaves a queued item unmatched, or leaves an unexpected one behind, once the request finishes.

// File: rtl/i3c_treq_pkg.sv
package i3c_treq_pkg;
    localparam int ADDR_W = 7;
    localparam int CNT_W  = 16;
    localparam int LIM_W  = 3;
    localparam int BYTE_W = 8;

    localparam logic [3:0]        KIND_HOTJOIN  = 4'd8;
    localparam logic [3:0]        KIND_CTRLROLE = 4'd9;
    localparam logic [3:0]        KIND_IBI      = 4'd10;
    localparam logic [ADDR_W-1:0] HOTJOIN_ADDR  = 7'h02;

    typedef enum logic [1:0] {
        SYM_START = 2'd0,
        SYM_HDR   = 2'd1,
        SYM_DATA  = 2'd2
    } sym_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_START,
        ST_HDR,
        ST_ACK,
        ST_DATA
    } state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] hdr;
        logic              has_pay;
        logic              bad_code;
        logic              over;
    } dec_t;

    function automatic logic [CNT_W-1:0] payload_limit(input logic [LIM_W-1:0] code);
        return CNT_W'(1) << code;
    endfunction
endpackage

// File: rtl/tgt_req_decode.sv
module tgt_req_decode
    import i3c_treq_pkg::*;
(
    input  logic [3:0]        kind,
    input  logic [ADDR_W-1:0] dyn,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [LIM_W-1:0]  code,
    input  logic              capable,
    output dec_t              dec
);
    logic is_ibi;

    assign is_ibi = (kind == KIND_IBI);

    always_comb begin
        dec          = '0;
        dec.bad_code = 1'b0;
        unique case (kind)
            KIND_HOTJOIN:  dec.hdr = {HOTJOIN_ADDR, 1'b0};
            KIND_CTRLROLE: dec.hdr = {dyn, 1'b0};
            KIND_IBI:      dec.hdr = {dyn, 1'b1};
            default:       dec.bad_code = 1'b1;
        endcase
        dec.over    = is_ibi && capable && (cnt > payload_limit(code));
        dec.has_pay = is_ibi && capable && (cnt != '0);
    end
endmodule

// File: rtl/tgt_pay_counter.sv
module tgt_pay_counter
    import i3c_treq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    output logic             last
);
    logic [CNT_W-1:0] remaining;

    always_ff @(posedge clk) begin
        if (rst) begin
            remaining <= '0;
        end else if (load) begin
            remaining <= load_val;
        end else if (step) begin
            remaining <= remaining - CNT_W'(1);
        end
    end

    assign last = (remaining == CNT_W'(1));

    // R9: never step a counter that has nothing left
    a_r9_no_underflow: assert property (@(posedge clk) disable iff (rst)
        step |-> (remaining != '0));
endmodule

// File: rtl/i3c_tgt_req_seq.sv
module i3c_tgt_req_seq
    import i3c_treq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [3:0]  req_kind,
    input  logic [6:0]  dyn_addr,
    input  logic [15:0] byte_cnt,
    input  logic [2:0]  max_code,
    input  logic        pay_capable,
    input  logic        bus_avail,
    input  logic        ctrl_start,
    input  logic        ack_valid,
    input  logic        ack_nack,
    input  logic [7:0]  pay_byte,
    output logic        pay_take,
    output logic        sym_valid,
    output logic [1:0]  sym_kind,
    output logic [7:0]  sym_data,
    output logic        sym_tbit,
    output logic        busy,
    output logic        done_o,
    output logic        nack_o,
    output logic        err_o
);
    state_e            state;
    dec_t              dec;
    logic [BYTE_W-1:0] hdr_q;
    logic              pay_q;
    logic              last;
    logic              accept;

    tgt_req_decode u_dec (
        .kind    (req_kind),
        .dyn     (dyn_addr),
        .cnt     (byte_cnt),
        .code    (max_code),
        .capable (pay_capable),
        .dec     (dec)
    );

    assign accept = (state == ST_IDLE) && req_valid && !dec.bad_code && !dec.over;

    tgt_pay_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (byte_cnt),
        .step     (state == ST_DATA),
        .last     (last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            hdr_q  <= '0;
            pay_q  <= 1'b0;
            done_o <= 1'b0;
            nack_o <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            nack_o <= 1'b0;
            err_o  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (dec.bad_code || dec.over) begin
                            err_o <= 1'b1;
                        end else begin
                            hdr_q <= dec.hdr;
                            pay_q <= dec.has_pay;
                            state <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (ctrl_start)     state <= ST_HDR;
                    else if (bus_avail) state <= ST_START;
                end
                ST_START: state <= ST_HDR;
                ST_HDR:   state <= ST_ACK;
                ST_ACK: begin
                    if (ack_valid) begin
                        if (ack_nack) begin
                            nack_o <= 1'b1;
                            state  <= ST_IDLE;
                        end else if (pay_q) begin
                            state  <= ST_DATA;
                        end else begin
                            done_o <= 1'b1;
                            state  <= ST_IDLE;
                        end
                    end
                end
                ST_DATA: begin
                    if (last) begin
                        done_o <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        sym_valid = 1'b0;
        sym_kind  = SYM_START;
        sym_data  = '0;
        sym_tbit  = 1'b0;
        unique case (state)
            ST_START: sym_valid = 1'b1;
            ST_HDR: begin
                sym_valid = 1'b1;
                sym_kind  = SYM_HDR;
                sym_data  = hdr_q;
            end
            ST_DATA: begin
                sym_valid = 1'b1;
                sym_kind  = SYM_DATA;
                sym_data  = pay_byte;
                sym_tbit  = !last;
            end
            default: ;
        endcase
    end

    assign pay_take = (state == ST_DATA);
    assign busy     = (state != ST_IDLE);

    // R5: a START symbol is always followed by the header symbol
    a_r5_start_then_hdr: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && sym_kind == SYM_START) |=> (sym_valid && sym_kind == SYM_HDR));

    // R10: a byte with a zero continuation bit closes the request
    a_r10_last_byte_closes: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && sym_kind == SYM_DATA && !sym_tbit) |=> (done_o && !busy));

    // R8: a NACK outcome leaves the block idle and silent
    a_r8_nack_idle: assert property (@(posedge clk) disable iff (rst)
        nack_o |-> (!busy && !sym_valid && !pay_take));

    // R1: at most one outcome pulse at a time
    a_r1_single_outcome: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done_o, nack_o, err_o}));

    // R12: the latched header does not change while a request runs
    a_r12_hdr_held: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(hdr_q));

    // R6: a refusal emits nothing
    a_r6_refusal_silent: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (!sym_valid && !busy));
endmodule

// File: tb/test_i3c_tgt_req_seq.sv
module test_i3c_tgt_req_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [3:0]  req_kind = '0;
    logic [6:0]  dyn_addr = '0;
    logic [15:0] byte_cnt = '0;
    logic [2:0]  max_code = '0;
    logic        pay_capable = 1'b0;
    logic        bus_avail = 1'b0;
    logic        ctrl_start = 1'b0;
    logic        ack_valid = 1'b0;
    logic        ack_nack = 1'b0;
    logic [7:0]  pay_byte;
    logic        pay_take, sym_valid, sym_tbit, busy, done_o, nack_o, err_o;
    logic [1:0]  sym_kind;
    logic [7:0]  sym_data;

    int checks = 0;
    int fails  = 0;
    logic [7:0] pay_idx = '0;
    logic [7:0] model_idx = '0;

    typedef struct {
        int         ev;   // 0 START, 1 HDR, 2 DATA, 3 DONE, 4 NACK, 5 ERR
        logic [7:0] d;
        logic       t;
        string      tag;
    } item_t;
    item_t exp_q[$];

    always #10 clk = ~clk;

    assign pay_byte = 8'h11 + pay_idx * 8'd3;
    always @(posedge clk) if (pay_take) pay_idx <= pay_idx + 8'd1;

    i3c_tgt_req_seq i_i3c_tgt_req_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .dyn_addr(dyn_addr), .byte_cnt(byte_cnt), .max_code(max_code),
        .pay_capable(pay_capable), .bus_avail(bus_avail), .ctrl_start(ctrl_start),
        .ack_valid(ack_valid), .ack_nack(ack_nack), .pay_byte(pay_byte),
        .pay_take(pay_take), .sym_valid(sym_valid), .sym_kind(sym_kind),
        .sym_data(sym_data), .sym_tbit(sym_tbit), .busy(busy),
        .done_o(done_o), .nack_o(nack_o), .err_o(err_o)
    );

    task automatic observe(input int ev, input logic [7:0] d, input logic t);
        item_t e;
        checks++;
        if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R12: unexpected event got ev=%0d d=%h t=%b expected none", ev, d, t);
            return;
        end
        e = exp_q.pop_front();
        if (e.ev != ev || ((ev == 1 || ev == 2) && e.d != d) || (ev == 2 && e.t != t)) begin
            fails++;
            $display("FAIL %s: got ev=%0d d=%h t=%b expected ev=%0d d=%h t=%b",
                     e.tag, ev, d, t, e.ev, e.d, e.t);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (sym_valid) observe(int'(sym_kind), sym_data, sym_tbit);
            if (done_o)    observe(3, 8'h00, 1'b0);
            if (nack_o)    observe(4, 8'h00, 1'b0);
            if (err_o)     observe(5, 8'h00, 1'b0);
        end
    end

    task automatic push(input int ev, input logic [7:0] d, input logic t, input string tag);
        item_t e;
        e.ev = ev; e.d = d; e.t = t; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic do_req(input logic [3:0] kind, input logic [6:0] da, input logic [15:0] cnt,
                          input logic [2:0] code, input logic cap, input logic via_bus,
                          input logic via_ctrl, input logic nack, input logic poke);
        logic bad, over;
        bad  = !(kind == 4'd8 || kind == 4'd9 || kind == 4'd10);
        over = (kind == 4'd10) && cap && (32'(cnt) > (32'd1 << code));
        if (bad) push(5, 8'h00, 1'b0, "R6");
        else if (over) push(5, 8'h00, 1'b0, "R7");
        else begin
            if (!via_ctrl) push(0, 8'h00, 1'b0, "R5");
            if (kind == 4'd8)      push(1, 8'h04, 1'b0, "R2");
            else if (kind == 4'd9) push(1, {da, 1'b0}, 1'b0, "R3");
            else                   push(1, {da, 1'b1}, 1'b0, "R4");
            if (nack) push(4, 8'h00, 1'b0, "R8");
            else if (kind == 4'd10 && cap && cnt != 0) begin
                for (int i = 0; i < int'(cnt); i++) begin
                    push(2, 8'h11 + model_idx * 8'd3, (i != int'(cnt) - 1), "R10");
                    model_idx = model_idx + 8'd1;
                end
                push(3, 8'h00, 1'b0, "R9");
            end else push(3, 8'h00, 1'b0, "R11");
        end
        @(negedge clk);
        req_kind = kind; dyn_addr = da; byte_cnt = cnt; max_code = code; pay_capable = cap;
        bus_avail = via_bus; ctrl_start = via_ctrl; ack_valid = 1'b1; ack_nack = nack;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            repeat (4) @(negedge clk);
            req_kind = 4'd8; req_valid = 1'b1;   // R12: arrives while busy
            @(negedge clk);
            req_valid = 1'b0;
        end
        repeat (int'(cnt) + 8) @(negedge clk);
        bus_avail = 1'b0; ctrl_start = 1'b0; ack_valid = 1'b0; ack_nack = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL R1: watchdog expired got running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;   // R1 reset state
        if (busy || sym_valid || pay_take || done_o || nack_o || err_o) begin
            fails++;
            $display("FAIL R1: reset outputs got %b expected 000000",
                     {busy, sym_valid, pay_take, done_o, nack_o, err_o});
        end
        rst = 1'b0;
        @(negedge clk);
        do_req(4'd8,  7'h35, 16'd0,  3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0); // R2 R5 R11
        do_req(4'd9,  7'h35, 16'd0,  3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0); // R3 R5
        do_req(4'd10, 7'h4B, 16'd3,  3'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0); // R4 R9 R10
        do_req(4'd10, 7'h12, 16'd4,  3'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0); // R7 limit exact
        do_req(4'd10, 7'h12, 16'd5,  3'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0); // R7 over
        do_req(4'd10, 7'h7F, 16'd100,3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0); // R11 no capability
        do_req(4'd10, 7'h01, 16'd0,  3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0); // R11 zero count
        do_req(4'd10, 7'h2C, 16'd6,  3'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0); // R8 NACK
        do_req(4'd9,  7'h2C, 16'd0,  3'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0); // R8 NACK on role request
        do_req(4'd3,  7'h2C, 16'd0,  3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0); // R6
        do_req(4'd11, 7'h2C, 16'd0,  3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0); // R6
        do_req(4'd8,  7'h00, 16'd0,  3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0); // R5 ctrl wins
        do_req(4'd10, 7'h55, 16'd8,  3'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1); // R12 poke while busy
        do_req(4'd10, 7'h66, 16'd1,  3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0); // R10 single byte
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL %s: missing events got %0d pending expected 0",
                     exp_q[0].tag, exp_q.size());
        end
        finish_run();
    end
endmodule